// File: doc/BRIEF.md
# Byte-Addressed Register Window for a Serial Slave

This block sits behind a two-wire serial slave whose bit-level protocol is already decoded into bytes. It maps the byte stream onto a 256-byte register space. In each write transaction, the first byte received sets an internal address pointer. Each later byte is stored at the pointer, and the pointer then steps forward. Each read returns the byte at the pointer and also steps it forward. The pointer rolls over from 0xFF to 0x00. A read transaction that sends no address byte picks up where the previous transaction stopped.

The space holds six registers:
- a bridge to an internal register bus, made of a data word and an address word;
- a read-only status summary;
- a mask that selects which status bits raise an alert;
- a control word;
- an outbound mailbox, filled by the internal side;
- an inbound mailbox, filled by the external master.

Storing the top byte of the bridge address word launches an internal-bus write request. The request stays up until the internal side accepts it. An access-status byte reports whether each mailbox is full, the alert flag and the bridge busy bit. Every 32-bit register is little-endian across its four bytes.

Top module: `sslv_regwin`

## Requirements
- R1: After `xfer_start_i`, the first byte on `wr_valid_i` loads the pointer and is not stored anywhere.
- R2: Each later write byte is stored at the pointer, and the pointer then advances by one. In 32-bit registers the byte at offset +0 is bits 7:0 and the byte at +3 is bits 31:24.
- R3: `rd_byte_o` shows the byte at the pointer, and each `rd_ack_i` advances the pointer. A read with no address byte continues from the pointer left by the previous transaction.
- R4: The pointer steps from 0xFF to 0x00, on a read and on a write.
- R5: Addresses 0x08–0x1F, 0x28–0x7F, 0x88–0x8F and 0x98–0xFF read zero and ignore writes. Writes to the status summary (0x80–0x83) and to the access-status register (0x20–0x23) are also ignored.
- R6: A write to byte 0x07 raises `bus_req_o` in the next cycle. At that point `bus_addr_o` holds bytes 0x04–0x07 and `bus_wdata_o` holds bytes 0x00–0x03. The request stays high until `bus_ack_i`. Bytes written at 0x00–0x06 do not raise it.
- R7: The alert flag is the OR of `stat_i & mask`, where the mask is at 0x84–0x87. It drives `alert_o`. The status summary reads back at 0x80–0x83.
- R8: A pulse on `mbox_out_wr_i` loads the outbound mailbox (read at 0x90–0x93) and sets its full flag. Reading byte 0x93 clears the flag. Reading bytes 0x90–0x92 does not clear it.
- R9: The external master writes the inbound mailbox at 0x94–0x97, and its contents appear on `mbox_in_data_o`. Writing byte 0x97 sets the inbound full flag, and `mbox_in_ack_i` clears it. Writing bytes 0x94–0x96 does not set it.
- R10: The control word at 0x24–0x27 is read/write and drives `ctrl_o`.
- R11: The access-status byte at 0x20 holds: bit 0 outbound full, bit 1 inbound full, bit 2 alert, bit 3 bridge busy. Bits 7:4 are zero, and bytes 0x21–0x23 read zero.
- R12: After reset the pointer is 0x00, every register and flag is zero, and `bus_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start_i | input | 1 | Pulse when a new serial transaction begins |
| wr_valid_i | input | 1 | A byte from the master is valid |
| wr_byte_i | input | 8 | Byte received from the master |
| rd_ack_i | input | 1 | The byte on `rd_byte_o` was sent to the master |
| rd_byte_o | output | 8 | Byte at the current pointer |
| stat_i | input | 32 | Internal status summary |
| mbox_out_wr_i | input | 1 | Internal side loads the outbound mailbox |
| mbox_out_data_i | input | 32 | Outbound mailbox data |
| mbox_out_full_o | output | 1 | Outbound mailbox not yet read by the master |
| mbox_in_ack_i | input | 1 | Internal side has taken the inbound mailbox |
| mbox_in_data_o | output | 32 | Inbound mailbox contents |
| mbox_in_full_o | output | 1 | Inbound mailbox holds a new message |
| bus_req_o | output | 1 | Internal-bus write request pending |
| bus_ack_i | input | 1 | Internal bus accepts the request |
| bus_addr_o | output | 32 | Internal-bus write address |
| bus_wdata_o | output | 32 | Internal-bus write data |
| ctrl_o | output | 32 | Control word |
| alert_o | output | 1 | Alert flag |

## Verification
The bench checks several boundary cases, and each one catches a specific fault:
- **Address byte stored as data.** A write starting at 0x25 checks that the address byte itself is not stored. A design that stored it would corrupt the control word.
- **Bridge launch.** The bench writes bytes 0x00–0x06 in one transaction and then byte 0x07 on its own. An early launch shows up after the first transaction, and a missing launch after the second. It then confirms the request stays up until acknowledged.
- **Pointer rollover.** A write that crosses 0xFF, and a read that crosses it, must land at 0x00. A design that saturated the pointer, or carried into a ninth bit, would read back the wrong byte.
- **Mailbox edges.** The outbound flag must survive partial reads and clear only on byte 0x93. The inbound flag must stay low until byte 0x97 is written.
- **Read-only and reserved areas.** Writes there are checked to leave read-back values unchanged.

// File: rtl/sslv_regwin_pkg.sv
package sslv_regwin_pkg;

    localparam int ADDR_W  = 8;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 32;
    localparam int LANES   = WORD_W / BYTE_W;
    localparam int LANE_W  = $clog2(LANES);
    localparam int INDEX_W = ADDR_W - LANE_W;

    localparam logic [ADDR_W-1:0] LAUNCH_BYTE   = 8'h07;
    localparam logic [ADDR_W-1:0] MOUT_LAST     = 8'h93;
    localparam logic [ADDR_W-1:0] MIN_LAST      = 8'h97;

    typedef enum logic [3:0] {
        SEL_WDATA, SEL_WADDR, SEL_ACC, SEL_CTRL,
        SEL_STAT, SEL_MASK, SEL_MOUT, SEL_MIN, SEL_NONE
    } win_sel_e;

    typedef struct packed {
        logic bus_busy;
        logic alert;
        logic in_full;
        logic out_full;
    } acc_stat_t;

    function automatic win_sel_e decode_word(input logic [INDEX_W-1:0] idx);
        case (idx)
            6'h00:   return SEL_WDATA;
            6'h01:   return SEL_WADDR;
            6'h08:   return SEL_ACC;
            6'h09:   return SEL_CTRL;
            6'h20:   return SEL_STAT;
            6'h21:   return SEL_MASK;
            6'h24:   return SEL_MOUT;
            6'h25:   return SEL_MIN;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] put_lane(input logic [WORD_W-1:0] word,
                                                   input logic [LANE_W-1:0] lane,
                                                   input logic [BYTE_W-1:0] b);
        logic [WORD_W-1:0] r;
        r = word;
        r[lane*BYTE_W +: BYTE_W] = b;
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] get_lane(input logic [WORD_W-1:0] word,
                                                   input logic [LANE_W-1:0] lane);
        return word[lane*BYTE_W +: BYTE_W];
    endfunction

endpackage

// File: rtl/sslv_ptr.sv
module sslv_ptr
    import sslv_regwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_start_i,
    input  logic              wr_valid_i,
    input  logic [BYTE_W-1:0] wr_byte_i,
    input  logic              rd_ack_i,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              addr_phase_o,
    output logic              data_wr_o
);
    logic [ADDR_W-1:0] ptr_q;
    logic              first_q;

    assign data_wr_o    = wr_valid_i && !first_q;
    assign ptr_o        = ptr_q;
    assign addr_phase_o = first_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            first_q <= 1'b0;
        end else begin
            if (xfer_start_i)
                first_q <= 1'b1;
            else if (wr_valid_i)
                first_q <= 1'b0;

            if (wr_valid_i && first_q)
                ptr_q <= wr_byte_i;
            else if (data_wr_o || rd_ack_i)
                ptr_q <= ptr_q + 1'b1;
        end
    end
endmodule

// File: rtl/sslv_regs.sv
module sslv_regs
    import sslv_regwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              data_wr_i,
    input  logic              rd_ack_i,
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic [BYTE_W-1:0] wr_byte_i,
    input  logic [WORD_W-1:0] stat_i,
    input  logic              mbox_out_wr_i,
    input  logic [WORD_W-1:0] mbox_out_data_i,
    input  logic              mbox_in_ack_i,
    input  logic              bus_ack_i,
    output logic [WORD_W-1:0] wdata_o,
    output logic [WORD_W-1:0] waddr_o,
    output logic [WORD_W-1:0] ctrl_o,
    output logic [WORD_W-1:0] mask_o,
    output logic [WORD_W-1:0] mout_o,
    output logic [WORD_W-1:0] min_o,
    output acc_stat_t         acc_o
);
    logic [WORD_W-1:0] wdata_q, waddr_q, ctrl_q, mask_q, mout_q, min_q;
    logic              busy_q, out_full_q, in_full_q;
    win_sel_e          sel;
    logic [LANE_W-1:0] lane;

    assign sel  = decode_word(ptr_i[ADDR_W-1:LANE_W]);
    assign lane = ptr_i[LANE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wdata_q <= '0;
            waddr_q <= '0;
            ctrl_q  <= '0;
            mask_q  <= '0;
            min_q   <= '0;
        end else if (data_wr_i) begin
            case (sel)
                SEL_WDATA: wdata_q <= put_lane(wdata_q, lane, wr_byte_i);
                SEL_WADDR: waddr_q <= put_lane(waddr_q, lane, wr_byte_i);
                SEL_CTRL:  ctrl_q  <= put_lane(ctrl_q,  lane, wr_byte_i);
                SEL_MASK:  mask_q  <= put_lane(mask_q,  lane, wr_byte_i);
                SEL_MIN:   min_q   <= put_lane(min_q,   lane, wr_byte_i);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q     <= 1'b0;
            out_full_q <= 1'b0;
            in_full_q  <= 1'b0;
            mout_q     <= '0;
        end else begin
            if (data_wr_i && ptr_i == LAUNCH_BYTE)
                busy_q <= 1'b1;
            else if (bus_ack_i)
                busy_q <= 1'b0;

            if (mbox_out_wr_i) begin
                mout_q     <= mbox_out_data_i;
                out_full_q <= 1'b1;
            end else if (rd_ack_i && ptr_i == MOUT_LAST) begin
                out_full_q <= 1'b0;
            end

            if (data_wr_i && ptr_i == MIN_LAST)
                in_full_q <= 1'b1;
            else if (mbox_in_ack_i)
                in_full_q <= 1'b0;
        end
    end

    assign wdata_o = wdata_q;
    assign waddr_o = waddr_q;
    assign ctrl_o  = ctrl_q;
    assign mask_o  = mask_q;
    assign mout_o  = mout_q;
    assign min_o   = min_q;
    assign acc_o   = '{bus_busy: busy_q,
                       alert:    |(stat_i & mask_q),
                       in_full:  in_full_q,
                       out_full: out_full_q};
endmodule

// File: rtl/sslv_rdmux.sv
module sslv_rdmux
    import sslv_regwin_pkg::*;
(
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [WORD_W-1:0] waddr_i,
    input  logic [WORD_W-1:0] ctrl_i,
    input  logic [WORD_W-1:0] mask_i,
    input  logic [WORD_W-1:0] stat_i,
    input  logic [WORD_W-1:0] mout_i,
    input  logic [WORD_W-1:0] min_i,
    input  acc_stat_t         acc_i,
    output logic [BYTE_W-1:0] rd_byte_o
);
    logic [WORD_W-1:0] word;

    always_comb begin
        case (decode_word(ptr_i[ADDR_W-1:LANE_W]))
            SEL_WDATA: word = wdata_i;
            SEL_WADDR: word = waddr_i;
            SEL_ACC:   word = WORD_W'(acc_i);
            SEL_CTRL:  word = ctrl_i;
            SEL_STAT:  word = stat_i;
            SEL_MASK:  word = mask_i;
            SEL_MOUT:  word = mout_i;
            SEL_MIN:   word = min_i;
            default:   word = '0;
        endcase
        rd_byte_o = get_lane(word, ptr_i[LANE_W-1:0]);
    end
endmodule

// File: rtl/sslv_regwin.sv
module sslv_regwin
    import sslv_regwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_start_i,
    input  logic              wr_valid_i,
    input  logic [BYTE_W-1:0] wr_byte_i,
    input  logic              rd_ack_i,
    output logic [BYTE_W-1:0] rd_byte_o,
    input  logic [WORD_W-1:0] stat_i,
    input  logic              mbox_out_wr_i,
    input  logic [WORD_W-1:0] mbox_out_data_i,
    output logic              mbox_out_full_o,
    input  logic              mbox_in_ack_i,
    output logic [WORD_W-1:0] mbox_in_data_o,
    output logic              mbox_in_full_o,
    output logic              bus_req_o,
    input  logic              bus_ack_i,
    output logic [WORD_W-1:0] bus_addr_o,
    output logic [WORD_W-1:0] bus_wdata_o,
    output logic [WORD_W-1:0] ctrl_o,
    output logic              alert_o
);
    logic [ADDR_W-1:0] ptr;
    logic              addr_phase;
    logic              data_wr;
    logic [WORD_W-1:0] wdata, waddr, ctrl, mask, mout, min;
    acc_stat_t         acc;

    sslv_ptr i_ptr (
        .clk, .rst, .xfer_start_i, .wr_valid_i, .wr_byte_i, .rd_ack_i,
        .ptr_o(ptr), .addr_phase_o(addr_phase), .data_wr_o(data_wr)
    );

    sslv_regs i_regs (
        .clk, .rst, .data_wr_i(data_wr), .rd_ack_i, .ptr_i(ptr), .wr_byte_i,
        .stat_i, .mbox_out_wr_i, .mbox_out_data_i, .mbox_in_ack_i, .bus_ack_i,
        .wdata_o(wdata), .waddr_o(waddr), .ctrl_o(ctrl), .mask_o(mask),
        .mout_o(mout), .min_o(min), .acc_o(acc)
    );

    sslv_rdmux i_rdmux (
        .ptr_i(ptr), .wdata_i(wdata), .waddr_i(waddr), .ctrl_i(ctrl),
        .mask_i(mask), .stat_i, .mout_i(mout), .min_i(min), .acc_i(acc),
        .rd_byte_o
    );

    assign bus_req_o       = acc.bus_busy;
    assign bus_addr_o      = waddr;
    assign bus_wdata_o     = wdata;
    assign ctrl_o          = ctrl;
    assign alert_o         = acc.alert;
    assign mbox_out_full_o = acc.out_full;
    assign mbox_in_full_o  = acc.in_full;
    assign mbox_in_data_o  = min;
endmodule

// File: rtl/sslv_regwin_chk.sv
module sslv_regwin_chk
    import sslv_regwin_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_valid_i,
    input logic [BYTE_W-1:0] wr_byte_i,
    input logic              rd_ack_i,
    input logic              bus_ack_i,
    input logic              mbox_in_ack_i,
    input logic              bus_req_o,
    input logic              mbox_in_full_o,
    input logic [BYTE_W-1:0] rd_byte_o,
    input logic [ADDR_W-1:0] ptr,
    input logic              addr_phase
);
    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_valid_i && addr_phase) |=> ptr == $past(wr_byte_i)); // R1

    AST_READ_STEP: assert property (@(posedge clk) disable iff (rst)
        (rd_ack_i && !wr_valid_i) |=> ptr == ADDR_W'($past(ptr) + 1'b1)); // R3

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
        ((rd_ack_i || (wr_valid_i && !addr_phase)) && ptr == 8'hFF) |=> ptr == 8'h00); // R4

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (decode_word(ptr[ADDR_W-1:LANE_W]) == SEL_NONE) |-> rd_byte_o == 8'h00); // R5

    AST_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (wr_valid_i && !addr_phase && ptr == LAUNCH_BYTE) |=> bus_req_o); // R6

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_req_o && !bus_ack_i && !(wr_valid_i && !addr_phase && ptr == LAUNCH_BYTE))
        |=> bus_req_o); // R6

    AST_INBOX_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (mbox_in_ack_i && !(wr_valid_i && !addr_phase && ptr == MIN_LAST))
        |=> !mbox_in_full_o); // R9
endmodule

bind sslv_regwin sslv_regwin_chk i_chk (
    .clk(clk), .rst(rst), .wr_valid_i(wr_valid_i), .wr_byte_i(wr_byte_i),
    .rd_ack_i(rd_ack_i), .bus_ack_i(bus_ack_i), .mbox_in_ack_i(mbox_in_ack_i),
    .bus_req_o(bus_req_o), .mbox_in_full_o(mbox_in_full_o),
    .rd_byte_o(rd_byte_o), .ptr(ptr), .addr_phase(addr_phase)
);

// File: tb/test_sslv_regwin.sv
`timescale 1ns/1ps
module test_sslv_regwin;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xfer_start_i = 1'b0, wr_valid_i = 1'b0, rd_ack_i = 1'b0;
    logic [7:0]  wr_byte_i = '0;
    logic [7:0]  rd_byte_o;
    logic [31:0] stat_i = '0, mbox_out_data_i = '0;
    logic        mbox_out_wr_i = 1'b0, mbox_in_ack_i = 1'b0, bus_ack_i = 1'b0;
    logic        mbox_out_full_o, mbox_in_full_o, bus_req_o, alert_o;
    logic [31:0] mbox_in_data_o, bus_addr_o, bus_wdata_o, ctrl_o;
    int checks = 0, errors = 0;
    logic [7:0] rb;

    always #2.5 clk = ~clk;

    sslv_regwin i_sslv_regwin (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(); @(negedge clk); endtask

    task automatic begin_txn(input logic [7:0] addr);
        xfer_start_i = 1'b1; cyc(); xfer_start_i = 1'b0;
        wr_valid_i = 1'b1; wr_byte_i = addr; cyc(); wr_valid_i = 1'b0;
    endtask

    task automatic put(input logic [7:0] b);
        wr_valid_i = 1'b1; wr_byte_i = b; cyc(); wr_valid_i = 1'b0;
    endtask

    task automatic get(output logic [7:0] b);
        b = rd_byte_o; rd_ack_i = 1'b1; cyc(); rd_ack_i = 1'b0;
    endtask

    task automatic peek(input logic [7:0] addr, output logic [7:0] b);
        begin_txn(addr); get(b);
    endtask

    task automatic t_reset();
        chk("R12 rd_byte", rd_byte_o, 0);
        chk("R12 bus_req", bus_req_o, 0);
        chk("R12 alert/flags", {alert_o, mbox_in_full_o, mbox_out_full_o}, 0);
        chk("R12 ctrl", ctrl_o, 0);
    endtask

    task automatic t_ctrl();
        begin_txn(8'h24); put(8'h11); put(8'h22); put(8'h33); put(8'h44);
        chk("R2 R10 ctrl little-endian", ctrl_o, 32'h44332211);
        begin_txn(8'h25); put(8'hAA);
        chk("R1 address byte not stored", ctrl_o, 32'h4433AA11);
        begin_txn(8'h24);
        get(rb); chk("R3 read 0x24", rb, 8'h11);
        get(rb); chk("R3 read 0x25", rb, 8'hAA);
        xfer_start_i = 1'b1; cyc(); xfer_start_i = 1'b0;
        get(rb); chk("R3 continue 0x26", rb, 8'h33);
        get(rb); chk("R3 continue 0x27", rb, 8'h44);
    endtask

    task automatic t_bus();
        begin_txn(8'h00);
        put(8'hDE); put(8'hAD); put(8'hBE); put(8'hEF);
        put(8'h78); put(8'h56); put(8'h34);
        chk("R6 no launch below 0x07", bus_req_o, 0);
        begin_txn(8'h07); put(8'h12);
        chk("R6 launch on 0x07", bus_req_o, 1);
        chk("R6 bus addr", bus_addr_o, 32'h12345678);
        chk("R6 bus data", bus_wdata_o, 32'hEFBEADDE);
        peek(8'h20, rb); chk("R11 busy bit", rb, 8'h08);
        repeat (3) cyc();
        chk("R6 held until ack", bus_req_o, 1);
        bus_ack_i = 1'b1; cyc(); bus_ack_i = 1'b0;
        chk("R6 cleared by ack", bus_req_o, 0);
        peek(8'h20, rb); chk("R11 busy clear", rb, 8'h00);
    endtask

    task automatic t_wrap();
        begin_txn(8'hFE); put(8'h55); put(8'h66); put(8'h77);
        peek(8'h00, rb); chk("R4 write wraps to 0x00", rb, 8'h77);
        begin_txn(8'hFF);
        get(rb); chk("R5 0xFF reads zero", rb, 8'h00);
        get(rb); chk("R4 read wraps to 0x00", rb, 8'h77);
    endtask

    task automatic t_reserved();
        begin_txn(8'h30); put(8'h5A);
        peek(8'h30, rb); chk("R5 reserved 0x30", rb, 8'h00);
        begin_txn(8'h8C); put(8'h5A);
        peek(8'h8C, rb); chk("R5 reserved 0x8C", rb, 8'h00);
        begin_txn(8'h10); put(8'h5A);
        peek(8'h10, rb); chk("R5 reserved 0x10", rb, 8'h00);
        begin_txn(8'h80); put(8'hFF);
        peek(8'h80, rb); chk("R5 status read-only", rb, 8'h00);
        begin_txn(8'h20); put(8'hFF);
        peek(8'h20, rb); chk("R5 access-status read-only", rb, 8'h00);
        peek(8'h21, rb); chk("R11 upper status byte", rb, 8'h00);
    endtask

    task automatic t_outbox();
        mbox_out_data_i = 32'hCAFEF00D; mbox_out_wr_i = 1'b1; cyc(); mbox_out_wr_i = 1'b0;
        chk("R8 full after load", mbox_out_full_o, 1);
        peek(8'h20, rb); chk("R11 out full bit", rb, 8'h01);
        begin_txn(8'h90);
        get(rb); chk("R8 byte 0x90", rb, 8'h0D);
        get(rb); chk("R8 byte 0x91", rb, 8'hF0);
        get(rb); chk("R8 byte 0x92", rb, 8'hFE);
        chk("R8 still full after partial", mbox_out_full_o, 1);
        get(rb); chk("R8 byte 0x93", rb, 8'hCA);
        chk("R8 cleared after 0x93", mbox_out_full_o, 0);
    endtask

    task automatic t_inbox();
        begin_txn(8'h94); put(8'h01); put(8'h02); put(8'h03);
        chk("R9 not full before 0x97", mbox_in_full_o, 0);
        begin_txn(8'h97); put(8'h04);
        chk("R9 full on 0x97", mbox_in_full_o, 1);
        chk("R9 inbox data", mbox_in_data_o, 32'h04030201);
        peek(8'h20, rb); chk("R11 in full bit", rb, 8'h02);
        mbox_in_ack_i = 1'b1; cyc(); mbox_in_ack_i = 1'b0;
        chk("R9 cleared by ack", mbox_in_full_o, 0);
    endtask

    task automatic t_alert();
        stat_i = 32'h0000_0100; cyc();
        chk("R7 no alert unmasked", alert_o, 0);
        begin_txn(8'h85); put(8'h01);
        chk("R7 alert when masked-in", alert_o, 1);
        peek(8'h20, rb); chk("R11 alert bit", rb, 8'h04);
        peek(8'h81, rb); chk("R7 status readback", rb, 8'h01);
        stat_i = 32'h0000_0200; cyc();
        chk("R7 alert drops", alert_o, 0);
        stat_i = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst = 1'b0; cyc();
        t_reset();
        t_ctrl();
        t_bus();
        t_wrap();
        t_reserved();
        t_outbox();
        t_inbox();
        t_alert();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule